// File: doc/BRIEF.md
# Clock Output Control

This block sits between the configuration registers of a clock generator and its output stage. It works out which frequency setting the synthesiser should run at, and which spread-spectrum profile goes with that setting. It also produces the global high-impedance request, the PLL-bypass test flag and the 24/48 MHz choice for the super-I/O clock.

The frequency code normally comes from four strap bits captured at power-up. A register override bit can replace them with a five-bit register field, which reaches twice as many settings. The block then looks up the spread profile for whichever code is in force.

Each clock output has its own enable, and each group of outputs has its own free-running source clock. An enable is carried into the source clock's domain through a synchroniser chain and is then retimed on the falling edge of that clock. A disabled output is therefore driven low, and switching an output on or off never produces a shortened high pulse.

Top module: `clkout_ctrl`

## Requirements
- R1: When `fsel_byte_i[3]` (override) is 0, `freq_code_o` equals `{1'b0, strap_fs_i[3:0]}` one `clk_i` cycle after the inputs are presented.
- R2: When `fsel_byte_i[3]` is 1, `freq_code_o` equals `{fsel_byte_i[2], fsel_byte_i[7], fsel_byte_i[6], fsel_byte_i[5], fsel_byte_i[4]}` (MSB to LSB) one cycle later.
- R3: `ss_mode_o` is registered together with the code and is encoded 0 = off, 1 = down-spread (-0.6%), 2 = center-spread (0.45%); 3 never appears. Codes 0, 7, 8, 10, 14, 15, 17, 19, 27 and 30 select down-spread. Codes 1, 3, 5 and 11 select center-spread. Every other code selects off.
- R4: `hiz_o` equals `hiz_req_i` of the previous cycle.
- R5: `pll_bypass_o` equals `bypass_req_i` of the previous cycle.
- R6: `sio_24m_o` equals `sio24_req_i` of the previous cycle (1 = 24 MHz, 0 = 48 MHz).
- R7: Bits of `out_en_i` and `clk_o` are ordered from the LSB up: CPU [2:0], PCI [9:3], SDRAM [23:10], REF [25:24], 48 MHz [26], SIO [27]. `src_clk_i` bits 0..5 follow the same group order. When an `out_en_i` bit is held at 0, the matching `clk_o` bit stays low once the synchroniser has settled.
- R8: When an `out_en_i` bit is held at 1, the matching `clk_o` bit repeats its group's source clock.
- R9: While `rst_ni` is low, all of `clk_o` is low, and once the first clock edge has reset the registers `freq_code_o`, `ss_mode_o`, `hiz_o`, `pll_bypass_o` and `sio_24m_o` read 0.
- R10: No `clk_o` bit is ever high while its group's source clock is low, even when its enable changes at arbitrary times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_fs_i | input | 4 | Latched power-up frequency straps |
| fsel_byte_i | input | 6 (bits 7:2) | Frequency register: bit 3 override, bits 7:4 and 2 select |
| hiz_req_i | input | 1 | Request to float all outputs |
| bypass_req_i | input | 1 | Request for PLL-bypass test mode |
| sio24_req_i | input | 1 | SIO rate select request |
| out_en_i | input | 28 | Per-output run enable |
| src_clk_i | input | 6 | Free-running source clock per group |
| freq_code_o | output | 5 | Frequency code in force |
| ss_mode_o | output | 2 | Spread-spectrum profile |
| hiz_o | output | 1 | Global high-impedance control |
| pll_bypass_o | output | 1 | PLL-bypass test flag |
| sio_24m_o | output | 1 | SIO runs at 24 MHz |
| clk_o | output | 28 | Gated clock outputs |

## Verification
The hardest case to reach is an enable that changes while its source clock is high. That is the moment when a careless gate would clip a pulse. The stimulus drives six source clocks with unrelated periods and rewrites the enables at non-aligned sub-nanosecond steps. The outputs are sampled at instants that never coincide with a source edge, so every enable change lands at many different points in the source phase. The decode path is swept over all 16 strap values and all 32 register codes, and then run on random patterns.

// File: rtl/clkout_ctrl_pkg.sv
`timescale 1ns/1ps
package clkout_ctrl_pkg;
   localparam int unsigned CODE_W = 5;

   typedef enum logic [1:0] {
      SS_OFF    = 2'd0,
      SS_DOWN   = 2'd1,
      SS_CENTER = 2'd2
   } ss_mode_e;

   // one bit per frequency code, set where the profile applies
   localparam logic [(1<<CODE_W)-1:0] DOWN_SET   = 32'h480A_C581;
   localparam logic [(1<<CODE_W)-1:0] CENTER_SET = 32'h0000_082A;

   function automatic ss_mode_e spread_of(input logic [CODE_W-1:0] code);
      if (DOWN_SET[code])
         return SS_DOWN;
      else if (CENTER_SET[code])
         return SS_CENTER;
      return SS_OFF;
   endfunction
endpackage

// File: rtl/clkout_freq_decode.sv
`timescale 1ns/1ps
module clkout_freq_decode
   import clkout_ctrl_pkg::*;
#(
   parameter int unsigned STRAP_W = 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [STRAP_W-1:0]  strap_i,
   input  logic [7:2]          fsel_byte_i,
   output logic [CODE_W-1:0]   code_o,
   output ss_mode_e            ss_mode_o
);
   localparam int unsigned PAD_W = CODE_W - STRAP_W;

   if (STRAP_W >= CODE_W || STRAP_W < 1) begin : g_bad_strap
      $error("clkout_freq_decode: STRAP_W must be 1..CODE_W-1");
   end

   logic [CODE_W-1:0] code_next;

   always_comb begin
      if (fsel_byte_i[3])
         code_next = {fsel_byte_i[2], fsel_byte_i[7], fsel_byte_i[6],
                      fsel_byte_i[5], fsel_byte_i[4]};
      else
         code_next = {{PAD_W{1'b0}}, strap_i};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_o    <= '0;
         ss_mode_o <= SS_OFF;
      end else begin
         code_o    <= code_next;
         ss_mode_o <= spread_of(code_next);
      end
   end
endmodule

// File: rtl/clkout_gate_bank.sv
`timescale 1ns/1ps
module clkout_gate_bank #(
   parameter int unsigned W           = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         src_clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] en_i,
   output logic [W-1:0] clk_o
);
   if (W < 1) begin : g_bad_w
      $error("clkout_gate_bank: W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clkout_gate_bank: SYNC_STAGES must be at least 2");
   end

   logic [W-1:0] sync_q [SYNC_STAGES];
   logic [W-1:0] en_low_q;

   // synchroniser chain in the source domain
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge src_clk_i or negedge rst_ni) begin
         if (!rst_ni)
            sync_q[s] <= '0;
         else if (s == 0)
            sync_q[s] <= en_i;
         else
            sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
   end

   // retimed while the source is low, so the AND never clips a pulse
   always_ff @(negedge src_clk_i or negedge rst_ni) begin
      if (!rst_ni)
         en_low_q <= '0;
      else
         en_low_q <= sync_q[SYNC_STAGES-1];
   end

   assign clk_o = en_low_q & {W{src_clk_i}};
endmodule

// File: rtl/clkout_ctrl.sv
`timescale 1ns/1ps
module clkout_ctrl
   import clkout_ctrl_pkg::*;
#(
   parameter int unsigned CPU_N       = 3,
   parameter int unsigned PCI_N       = 7,
   parameter int unsigned SDR_N       = 14,
   parameter int unsigned REF_N       = 2,
   parameter int unsigned USB_N       = 1,
   parameter int unsigned SIO_N       = 1,
   parameter int unsigned STRAP_W     = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NGRP       = 6,
   localparam int unsigned TOTAL      = CPU_N + PCI_N + SDR_N + REF_N + USB_N + SIO_N
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [STRAP_W-1:0] strap_fs_i,
   input  logic [7:2]         fsel_byte_i,
   input  logic               hiz_req_i,
   input  logic               bypass_req_i,
   input  logic               sio24_req_i,
   input  logic [TOTAL-1:0]   out_en_i,
   input  logic [NGRP-1:0]    src_clk_i,
   output logic [CODE_W-1:0]  freq_code_o,
   output logic [1:0]         ss_mode_o,
   output logic               hiz_o,
   output logic               pll_bypass_o,
   output logic               sio_24m_o,
   output logic [TOTAL-1:0]   clk_o
);
   localparam int unsigned GW [NGRP] = '{CPU_N, PCI_N, SDR_N, REF_N, USB_N, SIO_N};

   function automatic int unsigned base_of(input int unsigned g);
      int unsigned sum = 0;
      for (int unsigned i = 0; i < g; i++) sum += GW[i];
      return sum;
   endfunction

   ss_mode_e ss_q;

   clkout_freq_decode #(.STRAP_W(STRAP_W)) u_decode (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .strap_i     (strap_fs_i),
      .fsel_byte_i (fsel_byte_i),
      .code_o      (freq_code_o),
      .ss_mode_o   (ss_q)
   );
   assign ss_mode_o = ss_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hiz_o        <= 1'b0;
         pll_bypass_o <= 1'b0;
         sio_24m_o    <= 1'b0;
      end else begin
         hiz_o        <= hiz_req_i;
         pll_bypass_o <= bypass_req_i;
         sio_24m_o    <= sio24_req_i;
      end
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_bank
      localparam int unsigned BASE = base_of(g);
      clkout_gate_bank #(.W(GW[g]), .SYNC_STAGES(SYNC_STAGES)) u_bank (
         .src_clk_i (src_clk_i[g]),
         .rst_ni    (rst_ni),
         .en_i      (out_en_i[BASE +: GW[g]]),
         .clk_o     (clk_o[BASE +: GW[g]])
      );
   end
endmodule

// File: rtl/clkout_ctrl_chk.sv
`timescale 1ns/1ps
module clkout_ctrl_chk #(
   parameter int unsigned CPU_N       = 3,
   parameter int unsigned PCI_N       = 7,
   parameter int unsigned SDR_N       = 14,
   parameter int unsigned REF_N       = 2,
   parameter int unsigned USB_N       = 1,
   parameter int unsigned SIO_N       = 1,
   parameter int unsigned STRAP_W     = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NGRP       = 6,
   localparam int unsigned TOTAL      = CPU_N + PCI_N + SDR_N + REF_N + USB_N + SIO_N
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [STRAP_W-1:0] strap_fs_i,
   input logic [7:2]         fsel_byte_i,
   input logic               hiz_req_i,
   input logic               bypass_req_i,
   input logic               sio24_req_i,
   input logic [TOTAL-1:0]   out_en_i,
   input logic [NGRP-1:0]    src_clk_i,
   input logic [4:0]         freq_code_o,
   input logic [1:0]         ss_mode_o,
   input logic               hiz_o,
   input logic               pll_bypass_o,
   input logic               sio_24m_o,
   input logic [TOTAL-1:0]   clk_o
);
   logic [TOTAL-1:0] src_bits;
   assign src_bits = {{SIO_N{src_clk_i[5]}}, {USB_N{src_clk_i[4]}}, {REF_N{src_clk_i[3]}},
                      {SDR_N{src_clk_i[2]}}, {PCI_N{src_clk_i[1]}}, {CPU_N{src_clk_i[0]}}};

   logic unused_en;
   assign unused_en = ^out_en_i;

   assert_strap_path_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fsel_byte_i[3] |=> freq_code_o == {{(5-STRAP_W){1'b0}}, $past(strap_fs_i)});

   assert_reg_path_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fsel_byte_i[3] |=> freq_code_o == {$past(fsel_byte_i[2]), $past(fsel_byte_i[7:4])});

   assert_ss_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ss_mode_o != 2'd3);

   assert_ss_code2_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      freq_code_o == 5'd2 |-> ss_mode_o == 2'd0);

   assert_hiz_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hiz_req_i |=> hiz_o);

   assert_bypass_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bypass_req_i |=> pll_bypass_o);

   assert_sio_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sio24_req_i |=> !sio_24m_o);

   assert_reset_quiet_R9: assert property (@(posedge clk_i)
      !rst_ni |-> clk_o == '0);

   assert_no_runt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_o & ~src_bits) == '0);
endmodule

bind clkout_ctrl clkout_ctrl_chk #(
   .CPU_N(CPU_N), .PCI_N(PCI_N), .SDR_N(SDR_N), .REF_N(REF_N),
   .USB_N(USB_N), .SIO_N(SIO_N), .STRAP_W(STRAP_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/clkout_ctrl_tb.sv
`timescale 1ns/1ps
module clkout_ctrl_tb;
   localparam int TOT = 28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [3:0]  strap = '0;
   logic [7:2]  fsel = '0;
   logic        hiz_req = 1'b0, byp_req = 1'b0, sio_req = 1'b0;
   logic [TOT-1:0] out_en = '0;
   logic [5:0]  src = '0;
   logic [4:0]  code;
   logic [1:0]  ss;
   logic        hiz, byp, sio24;
   logic [TOT-1:0] gclk;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0, cmp_on = 1'b0;

   clkout_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .strap_fs_i(strap), .fsel_byte_i(fsel),
      .hiz_req_i(hiz_req), .bypass_req_i(byp_req), .sio24_req_i(sio_req),
      .out_en_i(out_en), .src_clk_i(src), .freq_code_o(code), .ss_mode_o(ss),
      .hiz_o(hiz), .pll_bypass_o(byp), .sio_24m_o(sio24), .clk_o(gclk)
   );

   always #2.5 clk = ~clk;
   always #3.5 src[0] = ~src[0];
   always #4.5 src[1] = ~src[1];
   always #5.5 src[2] = ~src[2];
   always #6.5 src[3] = ~src[3];
   always #3.0 src[4] = ~src[4];
   always #4.0 src[5] = ~src[5];

   logic [TOT-1:0] src_bits;
   assign src_bits = {src[5], src[4], {2{src[3]}}, {14{src[2]}}, {7{src[1]}}, {3{src[0]}}};

   // reference spread profile from the code lists
   function automatic int ref_ss(input int c);
      case (c)
         0, 7, 8, 10, 14, 15, 17, 19, 27, 30: return 1;
         1, 3, 5, 11:                         return 2;
         default:                             return 0;
      endcase
   endfunction

   int exp_code = 0, exp_ss = 0, exp_hiz = 0, exp_byp = 0, exp_sio = 0;

   always @(posedge clk) begin
      int c;
      if (!rst_n) begin
         exp_code <= 0; exp_ss <= 0; exp_hiz <= 0; exp_byp <= 0; exp_sio <= 0;
      end else begin
         if (fsel[3]) c = fsel[2] * 16 + fsel[7] * 8 + fsel[6] * 4 + fsel[5] * 2 + fsel[4];
         else         c = strap;
         exp_code <= c;
         exp_ss   <= ref_ss(c);
         exp_hiz  <= hiz_req;
         exp_byp  <= byp_req;
         exp_sio  <= sio_req;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference model
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         check(code == exp_code, fsel[3] ? "R2 code" : "R1 code", code, exp_code);
         check(ss == exp_ss, "R3 spread", ss, exp_ss);
         check(hiz == exp_hiz, "R4 hiz", hiz, exp_hiz);
         check(byp == exp_byp, "R5 bypass", byp, exp_byp);
         check(sio24 == exp_sio, "R6 sio", sio24, exp_sio);
      end
   end

   // observe gated outputs: enabled bits must pulse, disabled bits stay low
   task automatic observe_gates(input logic [TOT-1:0] en);
      logic [TOT-1:0] seen_hi = '0;
      logic [TOT-1:0] runt = '0;
      out_en = en;
      repeat (30) @(negedge clk);
      #0.37;
      for (int k = 0; k < 200; k++) begin
         seen_hi |= gclk;
         runt    |= gclk & ~src_bits;
         #1;
      end
      for (int b = 0; b < TOT; b++) begin
         if (en[b]) check(seen_hi[b], "R8 enabled output pulses", seen_hi[b], 1);
         else       check(!seen_hi[b], "R7 disabled output low", seen_hi[b], 0);
         check(!runt[b], "R10 high only with source", runt[b], 0);
      end
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (4) @(negedge clk);
      // R9: reset state
      check(gclk == '0, "R9 clocks low in reset", gclk, 0);
      check(code == 0, "R9 code reset", code, 0);
      check(ss == 0, "R9 spread reset", ss, 0);
      check({hiz, byp, sio24} == 3'b000, "R9 flags reset", {hiz, byp, sio24}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;

      // R1: every strap value with override clear
      for (int s = 0; s < 16; s++) begin
         fsel = 6'b000000; strap = s[3:0];
         @(negedge clk);
      end
      // R2/R3: every register code with override set
      for (int c = 0; c < 32; c++) begin
         fsel = {c[3], c[2], c[1], c[0], 1'b1, c[4]};
         strap = ~c[3:0];
         @(negedge clk);
      end
      // R4/R5/R6 and mixed decode on random patterns
      for (int i = 0; i < 300; i++) begin
         fsel = $urandom; strap = $urandom;
         {hiz_req, byp_req, sio_req} = $urandom;
         @(negedge clk);
      end

      // R7/R8/R10: enable patterns
      observe_gates('1);
      observe_gates('0);
      observe_gates(28'h5A5_3C69);
      observe_gates(28'hA5A_C396);

      // R10: enables rewritten at arbitrary phases
      @(negedge clk);
      #0.37;
      for (int i = 0; i < 3000; i++) begin
         if (i % 3 == 0) out_en = $urandom;
         check((gclk & ~src_bits) == '0, "R10 no runt on enable change",
               int'(gclk & ~src_bits), 0);
         #0.7;
      end

      @(negedge clk);
      cmp_on = 1'b0;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #60000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule